// File: doc/BRIEF.md
# Load/Store Address Generation Unit

This block takes one decoded load or store operation and works out everything that depends on the base register and the immediate offset. It produces the memory address of the access, the address of the second word when two words move together, and the value that is written back to the base register. It also decides whether that writeback happens. It checks the offset against the range that the indexing mode and the access size allow, and it rejects register combinations that cannot be executed. For loads it widens byte and halfword read data to 32 bits, signed or unsigned.

A word load whose destination is the program counter becomes a branch. The target is the loaded value with bit 0 cleared, and the loaded value must have bit 0 set. The logic is combinational. An optional register stage, chosen by a parameter, holds every output for one cycle.

Decode, the register file, the memory, alignment faults and condition flags are handled elsewhere.

Top module: `ldst_agu`

## Requirements
- R1: With `idxMode` 0 (plain offset), `memAddr` equals `baseVal` plus the sign-extended `offset`, and `wbEn` stays low. `idxMode` 3 is reserved and raises `errRegs`.
- R2: With `idxMode` 1 (pre-indexed), `memAddr` and `wbVal` both equal `baseVal` plus `offset`, and `wbEn` is high.
- R3: With `idxMode` 2 (post-indexed), `memAddr` equals the unmodified `baseVal`, `wbVal` equals `baseVal` plus `offset`, and `wbEn` is high.
- R4: All address arithmetic wraps modulo 2^32. `memAddr2` equals `memAddr` plus 4.
- R5: `accSize` 0 is byte, 1 is halfword and 2 is word. For these sizes, `errRange` rises when the offset lies outside -255..4095 in plain-offset mode, or outside -255..255 in pre- or post-indexed mode.
- R6: `accSize` 3 is a two-word access. For this size, `errRange` rises unless the offset is a multiple of 4 within -1020..1020, in every mode.
- R7: A two-word load with `dataIdx` equal to `data2Idx` raises `errRegs`. A two-word store with equal data registers is legal.
- R8: In pre- or post-indexed mode, `errRegs` rises when `baseIdx` equals `dataIdx`, or equals `data2Idx` for a two-word access. In plain-offset mode this overlap is legal.
- R9: Register index 13 is the stack pointer and index 15 is the program counter.
  - Loads may name either of them as `dataIdx` only for a word access.
  - Stores may not use the program counter as `dataIdx` or as `baseIdx`.
  - Stores may use the stack pointer as `dataIdx` only for a word access.
  - Neither index may be `data2Idx`.
  - Every violation raises `errRegs`.
- R10: While any error output is high, `reqValid`, `wbEn` and `brTaken` are low.
- R11: For loads, `ldData` is `rdData` zero-extended from 8 or 16 bits, or sign-extended when `signedLd` is 1. Word loads pass `rdData` through unchanged. For stores, `ldData` is 0.
- R12: A legal word load with `dataIdx` 15 sets `brTaken`, and `brTarget` is `rdData` with bit 0 cleared. If `rdData` bit 0 is 0, `errTarget` rises instead and no branch is taken.
- R13: With `OUT_REG` 1, the outputs show an operation one clock after it is presented, and every output is 0 while `rstN` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rstN | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | An operation is presented |
| isLoad | input | 1 | 1 for a load, 0 for a store |
| idxMode | input | 2 | 0 plain offset, 1 pre-indexed, 2 post-indexed, 3 reserved |
| accSize | input | 2 | 0 byte, 1 halfword, 2 word, 3 two words |
| signedLd | input | 1 | Sign-extend byte and halfword loads |
| baseIdx | input | REG_W | Base register index |
| dataIdx | input | REG_W | First data register index |
| data2Idx | input | REG_W | Second data register index (two-word accesses) |
| baseVal | input | XLEN | Current base register value |
| offset | input | OFS_W | Signed immediate offset |
| rdData | input | XLEN | Data read for a load |
| reqValid | output | 1 | Memory request is issued |
| memAddr | output | XLEN | Access address |
| memAddr2 | output | XLEN | Address of the second word |
| wbEn | output | 1 | Base register writeback enable |
| wbVal | output | XLEN | Base register writeback value |
| ldData | output | XLEN | Extended load data |
| brTaken | output | 1 | Load into the program counter becomes a branch |
| brTarget | output | XLEN | Branch target |
| errRange | output | 1 | Offset out of range for the mode and size |
| errRegs | output | 1 | Illegal register combination or reserved mode |
| errTarget | output | 1 | Program-counter load with bit 0 clear |

## Verification
The bench builds the block with `OUT_REG` set to 1 and the default 32-bit width, 4-bit register indices and 13-bit offset. The register stage brings the one-cycle latency and the all-zero reset state within reach of the checks. The 13-bit offset can express both ends of the plain-offset range, -255 and 4095. This lets the bench exercise every boundary of the range rules on both the legal and the illegal side.

// File: rtl/ldst_agu_pkg.sv
package ldst_agu_pkg;

  typedef enum logic [1:0] {
    IDX_OFFSET = 2'd0,
    IDX_PRE    = 2'd1,
    IDX_POST   = 2'd2,
    IDX_RSVD   = 2'd3
  } idxMode_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DUAL = 2'd3
  } accSize_e;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic     reqEn;
    logic     wbEn;
    logic     brEn;
    logic     addrFromBase;
    logic     signExt;
    logic     isLoad;
    accSize_e size;
  } agCtl_t;

endpackage

// File: rtl/ldst_agu_ctrl.sv
module ldst_agu_ctrl
  import ldst_agu_pkg::*;
#(
  parameter int REG_W       = 4,
  parameter int OFS_W       = 13,
  parameter int SP_IDX      = 13,
  parameter int PC_IDX      = 15,
  parameter int NEG_LIM     = 255,
  parameter int IMM_POS_LIM = 4095,
  parameter int IDX_POS_LIM = 255,
  parameter int DUAL_LIM    = 1020
) (
  input  logic                    opValid,
  input  logic                    isLoad,
  input  logic [1:0]              idxMode,
  input  logic [1:0]              accSize,
  input  logic                    signedLd,
  input  logic [REG_W-1:0]        baseIdx,
  input  logic [REG_W-1:0]        dataIdx,
  input  logic [REG_W-1:0]        data2Idx,
  input  logic signed [OFS_W-1:0] offset,
  input  logic                    rdBit0,
  output agCtl_t                  ctl,
  output logic                    errRange,
  output logic                    errRegs,
  output logic                    errTarget
);

  localparam logic [REG_W-1:0] SP_REG = REG_W'(SP_IDX);
  localparam logic [REG_W-1:0] PC_REG = REG_W'(PC_IDX);

  idxMode_e mode;
  accSize_e size;
  logic     isDual, doWb, rangeBad, regsBad, pcLoad, targetBad, anyErr;
  int       ofsInt;

  assign mode   = idxMode_e'(idxMode);
  assign size   = accSize_e'(accSize);
  assign isDual = (size == SZ_DUAL);
  assign doWb   = (mode == IDX_PRE) || (mode == IDX_POST);

  function automatic logic isSpPc(input logic [REG_W-1:0] r);
    return (r == SP_REG) || (r == PC_REG);
  endfunction

  // Offset range depends on size and mode
  always_comb begin
    ofsInt = int'(offset);
    if (isDual)
      rangeBad = (ofsInt < -DUAL_LIM) || (ofsInt > DUAL_LIM) || (offset[1:0] != 2'b00);
    else if (mode == IDX_OFFSET)
      rangeBad = (ofsInt < -NEG_LIM) || (ofsInt > IMM_POS_LIM);
    else
      rangeBad = (ofsInt < -NEG_LIM) || (ofsInt > IDX_POS_LIM);
  end

  // Register combination legality
  always_comb begin
    regsBad = 1'b0;
    if (mode == IDX_RSVD) regsBad = 1'b1;
    if (doWb && ((baseIdx == dataIdx) || (isDual && baseIdx == data2Idx))) regsBad = 1'b1;
    if (isDual && isSpPc(data2Idx)) regsBad = 1'b1;
    if (isLoad) begin
      if (isDual && dataIdx == data2Idx) regsBad = 1'b1;
      if (size != SZ_WORD && isSpPc(dataIdx)) regsBad = 1'b1;
    end else begin
      if (dataIdx == PC_REG || baseIdx == PC_REG) regsBad = 1'b1;
      if (dataIdx == SP_REG && size != SZ_WORD) regsBad = 1'b1;
    end
  end

  assign pcLoad    = isLoad && (size == SZ_WORD) && (dataIdx == PC_REG);
  assign targetBad = pcLoad && !rdBit0 && !rangeBad && !regsBad;
  assign anyErr    = rangeBad || regsBad || targetBad;

  assign errRange  = opValid && rangeBad;
  assign errRegs   = opValid && regsBad;
  assign errTarget = opValid && targetBad;

  always_comb begin
    ctl.reqEn        = opValid && !anyErr;
    ctl.wbEn         = opValid && !anyErr && doWb;
    ctl.brEn         = opValid && !anyErr && pcLoad;
    ctl.addrFromBase = (mode == IDX_POST);
    ctl.signExt      = signedLd;
    ctl.isLoad       = isLoad;
    ctl.size         = size;
  end

endmodule

// File: rtl/ldst_agu_dp.sv
module ldst_agu_dp
  import ldst_agu_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int OFS_W = 13
) (
  input  agCtl_t                  ctl,
  input  logic [XLEN-1:0]         baseVal,
  input  logic signed [OFS_W-1:0] offset,
  input  logic [XLEN-1:0]         rdData,
  output logic [XLEN-1:0]         memAddr,
  output logic [XLEN-1:0]         memAddr2,
  output logic [XLEN-1:0]         wbVal,
  output logic [XLEN-1:0]         ldData,
  output logic [XLEN-1:0]         brTarget
);

  localparam int EXT_W = XLEN - OFS_W;

  logic [XLEN-1:0] ofsExt, sum;

  assign ofsExt   = {{EXT_W{offset[OFS_W-1]}}, offset};
  assign sum      = baseVal + ofsExt;
  assign wbVal    = sum;
  assign memAddr  = ctl.addrFromBase ? baseVal : sum;
  assign memAddr2 = memAddr + XLEN'(4);
  assign brTarget = ctl.brEn ? {rdData[XLEN-1:1], 1'b0} : '0;

  always_comb begin
    ldData = '0;
    if (ctl.isLoad) begin
      unique case (ctl.size)
        SZ_BYTE: ldData = {{(XLEN-8){ctl.signExt & rdData[7]}}, rdData[7:0]};
        SZ_HALF: ldData = {{(XLEN-16){ctl.signExt & rdData[15]}}, rdData[15:0]};
        default: ldData = rdData;
      endcase
    end
  end

endmodule

// File: rtl/ldst_agu.sv
module ldst_agu
  import ldst_agu_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int REG_W   = 4,
  parameter int OFS_W   = 13,
  parameter int SP_IDX  = 13,
  parameter int PC_IDX  = 15,
  parameter bit OUT_REG = 1'b1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    opValid,
  input  logic                    isLoad,
  input  logic [1:0]              idxMode,
  input  logic [1:0]              accSize,
  input  logic                    signedLd,
  input  logic [REG_W-1:0]        baseIdx,
  input  logic [REG_W-1:0]        dataIdx,
  input  logic [REG_W-1:0]        data2Idx,
  input  logic [XLEN-1:0]         baseVal,
  input  logic signed [OFS_W-1:0] offset,
  input  logic [XLEN-1:0]         rdData,
  output logic                    reqValid,
  output logic [XLEN-1:0]         memAddr,
  output logic [XLEN-1:0]         memAddr2,
  output logic                    wbEn,
  output logic [XLEN-1:0]         wbVal,
  output logic [XLEN-1:0]         ldData,
  output logic                    brTaken,
  output logic [XLEN-1:0]         brTarget,
  output logic                    errRange,
  output logic                    errRegs,
  output logic                    errTarget
);

  localparam int PACK_W = 5 * XLEN + 6;

  agCtl_t            ctl;
  logic              eRange, eRegs, eTarget;
  logic [XLEN-1:0]   addrC, addr2C, wbValC, ldDataC, tgtC;
  logic [PACK_W-1:0] combPack, outPack;

  ldst_agu_ctrl #(
    .REG_W(REG_W), .OFS_W(OFS_W), .SP_IDX(SP_IDX), .PC_IDX(PC_IDX)
  ) uCtrl (
    .opValid(opValid), .isLoad(isLoad), .idxMode(idxMode), .accSize(accSize),
    .signedLd(signedLd), .baseIdx(baseIdx), .dataIdx(dataIdx), .data2Idx(data2Idx),
    .offset(offset), .rdBit0(rdData[0]), .ctl(ctl),
    .errRange(eRange), .errRegs(eRegs), .errTarget(eTarget)
  );

  ldst_agu_dp #(.XLEN(XLEN), .OFS_W(OFS_W)) uDp (
    .ctl(ctl), .baseVal(baseVal), .offset(offset), .rdData(rdData),
    .memAddr(addrC), .memAddr2(addr2C), .wbVal(wbValC), .ldData(ldDataC),
    .brTarget(tgtC)
  );

  assign combPack = {ctl.reqEn, ctl.wbEn, ctl.brEn, eRange, eRegs, eTarget,
                     addrC, addr2C, wbValC, ldDataC, tgtC};

  generate
    if (OUT_REG) begin : gRegOut
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) outPack <= '0;
        else       outPack <= combPack;
      end
    end else begin : gCombOut
      assign outPack = combPack;
    end
  endgenerate

  assign {reqValid, wbEn, brTaken, errRange, errRegs, errTarget,
          memAddr, memAddr2, wbVal, ldData, brTarget} = outPack;

endmodule

// File: rtl/ldst_agu_chk.sv
module ldst_agu_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic            reqValid,
  input logic [XLEN-1:0] memAddr,
  input logic [XLEN-1:0] memAddr2,
  input logic            wbEn,
  input logic            brTaken,
  input logic [XLEN-1:0] brTarget,
  input logic            errRange,
  input logic            errRegs,
  input logic            errTarget
);

  p_err_blocks_r10: assert property (@(posedge clk) disable iff (!rstN)
    (errRange || errRegs || errTarget) |-> (!reqValid && !wbEn && !brTaken));

  p_wb_needs_req_r2: assert property (@(posedge clk) disable iff (!rstN)
    wbEn |-> reqValid);

  p_second_word_r4: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (memAddr2 == memAddr + XLEN'(4)));

  p_branch_even_r12: assert property (@(posedge clk) disable iff (!rstN)
    brTaken |-> (reqValid && !errTarget && !brTarget[0]));

endmodule

bind ldst_agu ldst_agu_chk #(.XLEN(XLEN)) uChk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .memAddr(memAddr),
  .memAddr2(memAddr2), .wbEn(wbEn), .brTaken(brTaken), .brTarget(brTarget),
  .errRange(errRange), .errRegs(errRegs), .errTarget(errTarget)
);

// File: tb/tb_ldst_agu.sv
module tb_ldst_agu;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0, isLoad = 1'b0, signedLd = 1'b0;
  logic [1:0]  idxMode = '0, accSize = '0;
  logic [3:0]  baseIdx = '0, dataIdx = '0, data2Idx = '0;
  logic [31:0] baseVal = '0, rdData = '0;
  logic signed [12:0] offset = '0;
  logic        reqValid, wbEn, brTaken, errRange, errRegs, errTarget;
  logic [31:0] memAddr, memAddr2, wbVal, ldData, brTarget;

  always #5 clk = ~clk;

  ldst_agu #(.OUT_REG(1'b1)) dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .isLoad(isLoad), .idxMode(idxMode),
    .accSize(accSize), .signedLd(signedLd), .baseIdx(baseIdx), .dataIdx(dataIdx),
    .data2Idx(data2Idx), .baseVal(baseVal), .offset(offset), .rdData(rdData),
    .reqValid(reqValid), .memAddr(memAddr), .memAddr2(memAddr2), .wbEn(wbEn),
    .wbVal(wbVal), .ldData(ldData), .brTaken(brTaken), .brTarget(brTarget),
    .errRange(errRange), .errRegs(errRegs), .errTarget(errTarget)
  );

  typedef struct {
    string       tag;
    int          cyc;
    logic        req, wb, br, eR, eG, eT;
    logic [31:0] addr, addr2, wbv, ld, tgt;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   nCmp = 0, nBad = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic exp_t model(input string tag, input bit ld, input int md, input int sz,
                                 input bit sg, input int b, input int d, input int d2,
                                 input logic [31:0] bv, input int ofs, input logic [31:0] rd);
    exp_t e;
    logic [31:0] sum;
    bit dual, wbm, rBad, gBad, pcLd, spPc1, spPc2;
    e.tag = tag;
    e.cyc = 0;
    sum   = bv + ofs;
    dual  = (sz == 3);
    wbm   = (md == 1) || (md == 2);
    if (dual)         rBad = (ofs < -1020) || (ofs > 1020) || (ofs % 4 != 0);
    else if (md == 0) rBad = (ofs < -255) || (ofs > 4095);
    else              rBad = (ofs < -255) || (ofs > 255);
    spPc1 = (d == 13) || (d == 15);
    spPc2 = (d2 == 13) || (d2 == 15);
    gBad  = (md == 3);
    if (wbm && (b == d || (dual && b == d2))) gBad = 1;
    if (dual && spPc2) gBad = 1;
    if (ld) begin
      if (dual && d == d2) gBad = 1;
      if (sz != 2 && spPc1) gBad = 1;
    end else begin
      if (d == 15 || b == 15) gBad = 1;
      if (d == 13 && sz != 2) gBad = 1;
    end
    pcLd  = ld && sz == 2 && d == 15;
    e.eR  = rBad;
    e.eG  = gBad;
    e.eT  = pcLd && !rd[0] && !rBad && !gBad;
    e.req = !(e.eR || e.eG || e.eT);
    e.wb  = e.req && wbm;
    e.br  = e.req && pcLd;
    e.addr  = (md == 2) ? bv : sum;
    e.addr2 = e.addr + 32'd4;
    e.wbv   = sum;
    if (!ld)          e.ld = 32'h0;
    else if (sz == 0) e.ld = sg ? {{24{rd[7]}}, rd[7:0]} : {24'h0, rd[7:0]};
    else if (sz == 1) e.ld = sg ? {{16{rd[15]}}, rd[15:0]} : {16'h0, rd[15:0]};
    else              e.ld = rd;
    e.tgt = {rd[31:1], 1'b0};
    return e;
  endfunction

  task automatic doOp(input string tag, input bit ld, input int md, input int sz, input bit sg,
                      input int b, input int d, input int d2, input logic [31:0] bv,
                      input int ofs, input logic [31:0] rd);
    exp_t e;
    @(posedge clk);
    #1;
    opValid  = 1'b1;
    isLoad   = ld;
    idxMode  = 2'(md);
    accSize  = 2'(sz);
    signedLd = sg;
    baseIdx  = 4'(b);
    dataIdx  = 4'(d);
    data2Idx = 4'(d2);
    baseVal  = bv;
    offset   = 13'(ofs);
    rdData   = rd;
    e = model(tag, ld, md, sz, sg, b, d, d2, bv, ofs, rd);
    e.cyc = cyc;
    q.push_back(e);
  endtask

  // Monitor: one cycle of latency through the output stage (R13)
  always @(negedge clk) begin
    if (rstN && q.size() > 0 && q[0].cyc < cyc) begin
      exp_t e;
      e = q.pop_front();
      chk(e.tag, "reqValid", 32'(reqValid), 32'(e.req));
      chk(e.tag, "wbEn", 32'(wbEn), 32'(e.wb));
      chk(e.tag, "brTaken", 32'(brTaken), 32'(e.br));
      chk(e.tag, "errRange", 32'(errRange), 32'(e.eR));
      chk(e.tag, "errRegs", 32'(errRegs), 32'(e.eG));
      chk(e.tag, "errTarget", 32'(errTarget), 32'(e.eT));
      if (e.req) begin
        chk(e.tag, "memAddr", memAddr, e.addr);
        chk(e.tag, "memAddr2", memAddr2, e.addr2);
        chk(e.tag, "ldData", ldData, e.ld);
      end
      if (e.wb) chk(e.tag, "wbVal", wbVal, e.wbv);
      if (e.br) chk(e.tag, "brTarget", brTarget, e.tgt);
    end
  end

  initial begin
    #2_000_000;
    nBad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    // R13: outputs held at zero in reset even with a legal op presented
    opValid = 1'b1; isLoad = 1'b1; accSize = 2'd2; baseVal = 32'h100; offset = 13'sd4;
    dataIdx = 4'd2; baseIdx = 4'd1; rdData = 32'h5;
    repeat (3) @(negedge clk);
    chk("R13", "reset reqValid", 32'(reqValid), 32'h0);
    chk("R13", "reset memAddr", memAddr, 32'h0);
    chk("R13", "reset ldData", ldData, 32'h0);
    rstN = 1'b1;

    // R1 plain offset; reserved mode
    doOp("R1", 1, 0, 2, 0, 1, 2, 0, 32'h1000, 100, 32'h1111);
    doOp("R1", 1, 3, 2, 0, 1, 2, 0, 32'h1000, 4, 32'h0);
    // R2 pre-indexed
    doOp("R2", 1, 1, 2, 0, 1, 2, 0, 32'h1000, -16, 32'h2222);
    // R3 post-indexed store
    doOp("R3", 0, 2, 2, 0, 1, 2, 0, 32'h1000, 255, 32'h0);
    // R4 wrap and second word
    doOp("R4", 1, 0, 2, 0, 1, 2, 0, 32'hFFFF_FFF0, 32, 32'h0);
    doOp("R4", 1, 0, 3, 0, 1, 2, 3, 32'h2000, 8, 32'h0);
    doOp("R4", 0, 0, 3, 0, 1, 2, 3, 32'hFFFF_FFFC, 0, 32'h0);
    // R5 single-size range limits
    doOp("R5", 1, 0, 2, 0, 1, 2, 0, 32'h0, 4095, 32'h0);
    doOp("R5", 1, 0, 0, 0, 1, 2, 0, 32'h400, -255, 32'h0);
    doOp("R5", 1, 0, 1, 0, 1, 2, 0, 32'h400, -256, 32'h0);
    doOp("R5", 1, 1, 2, 0, 1, 2, 0, 32'h400, 256, 32'h0);
    doOp("R5", 0, 2, 2, 0, 1, 2, 0, 32'h400, -256, 32'h0);
    doOp("R5", 0, 2, 0, 0, 1, 2, 0, 32'h400, 255, 32'h0);
    // R6 two-word range
    doOp("R6", 1, 1, 3, 0, 1, 2, 3, 32'h4000, 1020, 32'h0);
    doOp("R6", 1, 0, 3, 0, 1, 2, 3, 32'h4000, 1024, 32'h0);
    doOp("R6", 1, 0, 3, 0, 1, 2, 3, 32'h4000, 6, 32'h0);
    doOp("R6", 0, 2, 3, 0, 1, 2, 3, 32'h4000, -1020, 32'h0);
    doOp("R6", 0, 0, 3, 0, 1, 2, 3, 32'h4000, -1024, 32'h0);
    // R7 two-word destination overlap
    doOp("R7", 1, 0, 3, 0, 1, 4, 4, 32'h4000, 8, 32'h0);
    doOp("R7", 0, 0, 3, 0, 1, 4, 4, 32'h4000, 8, 32'h0);
    // R8 base/data overlap with writeback
    doOp("R8", 1, 1, 2, 0, 5, 5, 0, 32'h4000, 4, 32'h0);
    doOp("R8", 0, 2, 3, 0, 6, 2, 6, 32'h4000, 8, 32'h0);
    doOp("R8", 1, 0, 2, 0, 5, 5, 0, 32'h4000, 4, 32'h77);
    // R9 stack pointer / program counter rules
    doOp("R9", 1, 0, 0, 0, 1, 15, 0, 32'h4000, 0, 32'h0);
    doOp("R9", 1, 0, 2, 0, 1, 13, 0, 32'h4000, 0, 32'h99);
    doOp("R9", 0, 0, 2, 0, 1, 15, 0, 32'h4000, 0, 32'h0);
    doOp("R9", 0, 0, 2, 0, 15, 2, 0, 32'h4000, 0, 32'h0);
    doOp("R9", 0, 0, 0, 0, 1, 13, 0, 32'h4000, 0, 32'h0);
    doOp("R9", 0, 0, 2, 0, 1, 13, 0, 32'h4000, 0, 32'h0);
    doOp("R9", 1, 0, 3, 0, 1, 2, 15, 32'h4000, 0, 32'h0);
    // R11 extension
    doOp("R11", 1, 0, 0, 1, 1, 2, 0, 32'h0, 0, 32'hABCD_EF80);
    doOp("R11", 1, 0, 0, 0, 1, 2, 0, 32'h0, 0, 32'hABCD_EF80);
    doOp("R11", 1, 0, 1, 1, 1, 2, 0, 32'h0, 0, 32'h1234_8001);
    doOp("R11", 1, 0, 1, 0, 1, 2, 0, 32'h0, 0, 32'h1234_8001);
    doOp("R11", 0, 0, 1, 1, 1, 2, 0, 32'h0, 0, 32'hFFFF_FFFF);
    // R12 load to program counter
    doOp("R12", 1, 0, 2, 0, 1, 15, 0, 32'h8000, 4, 32'h0800_0101);
    doOp("R12", 1, 2, 2, 0, 1, 15, 0, 32'h8000, 4, 32'h0800_0100);
    // R10 error suppression is checked on every illegal op above
    doOp("R10", 1, 1, 2, 0, 3, 3, 0, 32'h8000, 300, 32'h0);

    @(posedge clk);
    #1;
    opValid = 1'b0;
    wait (q.size() == 0);
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule